// File: doc/BRIEF.md
# Standby Sequencer with Oscillator Warm-Up

This block moves a device between a running state and three halt depths. A single-cycle halt strobe, qualified by a 2-bit depth code, picks the target: a light idle that stops only the processor clock, a deeper idle that also stops the peripheral clock while the oscillator keeps running, and a full stop in which the oscillator is switched off as well. A wake pulse from the interrupt logic brings the device back to the running state.

Leaving the full stop is not immediate: the oscillator enable comes back first, and the processor and peripheral clock enables stay low until a warm-up count of a selectable power of two of input-clock cycles has elapsed. A busy flag is high for exactly that window. A pin-hold output tells the pad ring to freeze output pins, and a select bit captured at halt entry chooses whether this applies to the full stop or to the deep idle.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the block is running: cpu_clk_en, per_clk_en and osc_en are 1, warmup_busy and pin_hold are 0.
- R2: A halt strobe in the running state with depth code 2'b11 makes, from the next cycle, cpu_clk_en 0 while per_clk_en and osc_en stay 1.
- R3: A halt strobe in the running state with depth code 2'b10 makes, from the next cycle, cpu_clk_en and per_clk_en 0 while osc_en stays 1.
- R4: A halt strobe in the running state with depth code 2'b01 makes, from the next cycle, all three clock enables 0.
- R5: A halt strobe with depth code 2'b00 is ignored: the block stays running with all enables 1.
- R6: A wake pulse in either idle depth returns all enables to 1 on the next cycle, with warmup_busy staying 0.
- R7: A wake pulse in the full stop sets osc_en 1 and warmup_busy 1 on the next cycle, with cpu_clk_en and per_clk_en 0, for exactly 2^E cycles, after which all enables are 1 and warmup_busy 0; warm-up code 2'b01, 2'b10 and 2'b11 give E = WUP_EXP1, WUP_EXP2, WUP_EXP3 (defaults 8, 14, 16) and code 2'b00 gives E = WUP_EXP3; the code is sampled with the wake pulse.
- R8: A wake pulse during the warm-up window neither shortens nor restarts it.
- R9: A halt strobe outside the running state and a wake pulse in the running state have no effect on any output.
- R10: The pin-hold select is sampled with the accepted halt strobe; with select 0 pin_hold is 1 during the full stop and its warm-up, with select 1 pin_hold is 1 during the deep idle, and pin_hold is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | One-cycle halt strobe |
| halt_depth | input | 2 | Halt depth code: 01 full stop, 10 deep idle, 11 light idle, 00 reserved |
| wup_code | input | 2 | Warm-up length code, sampled with the wake pulse |
| hold_sel | input | 1 | Pin-hold target: 0 full stop, 1 deep idle; sampled with the halt strobe |
| wake | input | 1 | Wake pulse from interrupt logic |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| warmup_busy | output | 1 | High while the oscillator warm-up count runs |
| pin_hold | output | 1 | Request to freeze output pin states |

## Verification
The hardest situation to reach is a wake pulse landing inside the warm-up window at an arbitrary count, combined with a warm-up code that changes between the halt and the wake. The bench shrinks the warm-up exponents through parameters so that every code can be run to completion many times, and its random phase drives wake with high probability while a cycle-accurate model tracks the remaining count. Directed runs measure the busy window length for every code, including the reserved one.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_IDLE_IO  = 3'd1,
        ST_IDLE_OSC = 3'd2,
        ST_STOP     = 3'd3,
        ST_WARM     = 3'd4
    } stby_state_e;

    localparam logic [1:0] DEPTH_RSVD = 2'b00;
    localparam logic [1:0] DEPTH_STOP = 2'b01;
    localparam logic [1:0] DEPTH_OSC  = 2'b10;
    localparam logic [1:0] DEPTH_IO   = 2'b11;

endpackage

// File: rtl/stby_warm_timer.sv
module stby_warm_timer #(
    parameter int WUP_EXP1 = 8,
    parameter int WUP_EXP2 = 14,
    parameter int WUP_EXP3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code,
    input  logic       run,
    output logic       done
);
    localparam int CNT_W = WUP_EXP3;
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        unique case (code)
            2'b01:   load_val = ONES >> (CNT_W - WUP_EXP1);
            2'b10:   load_val = ONES >> (CNT_W - WUP_EXP2);
            default: load_val = ONES;
        endcase
    end

    assign done = (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (run && !done)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: a running count only ever steps down by one, nothing reloads it mid-window
    a_r8_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R7: the count holds at zero once finished until a new load
    a_r7_done_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

endmodule

// File: rtl/stby_domain_gate.sv
module stby_domain_gate
    import stby_pkg::*;
(
    input  stby_state_e state,
    input  logic        hold_sel_q,
    output logic        cpu_clk_en,
    output logic        per_clk_en,
    output logic        osc_en,
    output logic        warmup_busy,
    output logic        pin_hold
);
    always_comb begin
        cpu_clk_en  = 1'b0;
        per_clk_en  = 1'b0;
        osc_en      = 1'b1;
        warmup_busy = 1'b0;
        pin_hold    = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
            end
            ST_IDLE_IO: begin
                per_clk_en = 1'b1;
            end
            ST_IDLE_OSC: begin
                pin_hold = hold_sel_q;
            end
            ST_STOP: begin
                osc_en   = 1'b0;
                pin_hold = !hold_sel_q;
            end
            ST_WARM: begin
                warmup_busy = 1'b1;
                pin_hold    = !hold_sel_q;
            end
            default: begin
                cpu_clk_en = 1'b1;
                per_clk_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int WUP_EXP1 = 8,
    parameter int WUP_EXP2 = 14,
    parameter int WUP_EXP3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic [1:0] halt_depth,
    input  logic [1:0] wup_code,
    input  logic       hold_sel,
    input  logic       wake,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       warmup_busy,
    output logic       pin_hold
);
    typedef struct packed {
        stby_state_e state;
        logic        hold_sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tmr_load;
    logic tmr_run;
    logic tmr_done;

    assign tmr_load = (ctl_q.state == ST_STOP) && wake;
    assign tmr_run  = (ctl_q.state == ST_WARM);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (halt_req && halt_depth != DEPTH_RSVD) begin
                    ctl_d.hold_sel = hold_sel;
                    unique case (halt_depth)
                        DEPTH_STOP: ctl_d.state = ST_STOP;
                        DEPTH_OSC:  ctl_d.state = ST_IDLE_OSC;
                        default:    ctl_d.state = ST_IDLE_IO;
                    endcase
                end
            end
            ST_IDLE_IO, ST_IDLE_OSC: begin
                if (wake) ctl_d.state = ST_RUN;
            end
            ST_STOP: begin
                if (wake) ctl_d.state = ST_WARM;
            end
            ST_WARM: begin
                if (tmr_done) ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_RUN;
            ctl_q.hold_sel <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    stby_warm_timer #(
        .WUP_EXP1 (WUP_EXP1),
        .WUP_EXP2 (WUP_EXP2),
        .WUP_EXP3 (WUP_EXP3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .code  (wup_code),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    stby_domain_gate u_gate (
        .state       (ctl_q.state),
        .hold_sel_q  (ctl_q.hold_sel),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .warmup_busy (warmup_busy),
        .pin_hold    (pin_hold)
    );

    // R5: reserved depth leaves the processor clock running
    a_r5_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && halt_req && halt_depth == DEPTH_RSVD) |=> cpu_clk_en);

    // R6: wake from the light idle resumes on the next cycle
    a_r6_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && per_clk_en && wake) |=> (cpu_clk_en && !warmup_busy));

    // R7: leaving the full stop restarts the oscillator and enters warm-up
    a_r7_stop_to_warm: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && wake) |=> (osc_en && warmup_busy && !cpu_clk_en));

    // R8: busy cannot drop while the count is still running
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (warmup_busy && !tmr_done) |=> warmup_busy);

    // R9: wake in the running state leaves it running
    a_r9_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !halt_req) |=> cpu_clk_en);

endmodule

// File: tb/stby_ctrl_tb.sv
module stby_ctrl_tb;
    localparam int E1 = 3;
    localparam int E2 = 5;
    localparam int E3 = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0;
    logic [1:0] halt_depth = 2'b00;
    logic [1:0] wup_code = 2'b00;
    logic       hold_sel = 1'b0;
    logic       wake = 1'b0;
    logic       cpu_clk_en, per_clk_en, osc_en, warmup_busy, pin_hold;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // model: 0 run, 1 light idle, 2 deep idle, 3 stop, 4 warm-up
    int m_st = 0;
    int m_cnt = 0;
    logic m_sel = 1'b0;

    always #5 clk = ~clk;

    stby_ctrl #(.WUP_EXP1(E1), .WUP_EXP2(E2), .WUP_EXP3(E3)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .halt_depth(halt_depth),
        .wup_code(wup_code), .hold_sel(hold_sel), .wake(wake),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .warmup_busy(warmup_busy), .pin_hold(pin_hold)
    );

    function automatic int warm_len(input logic [1:0] c);
        case (c)
            2'b01:   return 1 << E1;
            2'b10:   return 1 << E2;
            default: return 1 << E3;
        endcase
    endfunction

    function automatic logic [4:0] exp_out(input int st, input logic sel);
        // {cpu, per, osc, busy, hold}
        case (st)
            0: return 5'b11100;
            1: return 5'b01100;
            2: return {4'b0010, sel};
            3: return {4'b0000, !sel};
            default: return {4'b0011, !sel};
        endcase
    endfunction

    task automatic check(input string tag);
        logic [4:0] act;
        logic [4:0] exp;
        act = {cpu_clk_en, per_clk_en, osc_en, warmup_busy, pin_hold};
        exp = exp_out(m_st, m_sel);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs actual=%b expected=%b (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic model_edge();
        case (m_st)
            0: if (halt_req && halt_depth != 2'b00) begin
                   m_sel = hold_sel;
                   m_st = (halt_depth == 2'b01) ? 3 : (halt_depth == 2'b10) ? 2 : 1;
               end
            1, 2: if (wake) m_st = 0;
            3: if (wake) begin m_st = 4; m_cnt = warm_len(wup_code) - 1; end
            default: if (m_cnt == 0) m_st = 0; else m_cnt--;
        endcase
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        cycles++;
        model_edge();
        #2;
        check(tag);
        @(negedge clk);
        halt_req = 1'b0;
        wake = 1'b0;
    endtask

    task automatic do_halt(input logic [1:0] d, input logic s, input string tag);
        halt_req = 1'b1; halt_depth = d; hold_sel = s;
        step(tag);
    endtask

    task automatic do_wake(input logic [1:0] c, input string tag);
        wake = 1'b1; wup_code = c;
        step(tag);
    endtask

    task automatic measure_warm(input logic [1:0] c, input string tag);
        int n;
        do_halt(2'b01, 1'b0, "R4");
        do_wake(c, tag);
        n = 0;
        while (warmup_busy === 1'b1 && n < 1000) begin
            n++;
            step(tag);
        end
        total++;
        if (n != warm_len(c)) begin
            bad++;
            $display("FAIL %s: warm-up length actual=%0d expected=%0d", tag, n, warm_len(c));
        end
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #22 rst_n = 1'b1;
        @(negedge clk);
        #0 check("R1");
        step("R1");

        do_halt(2'b11, 1'b0, "R2");
        step("R2");
        do_halt(2'b01, 1'b0, "R9");      // ignored outside run
        do_wake(2'b01, "R6");

        do_halt(2'b10, 1'b1, "R3");
        step("R10");
        do_wake(2'b01, "R6");

        do_halt(2'b00, 1'b1, "R5");
        step("R5");
        wake = 1'b1; step("R9");

        do_halt(2'b10, 1'b0, "R10");     // deep idle, no hold
        do_wake(2'b11, "R6");

        measure_warm(2'b01, "R7");
        measure_warm(2'b10, "R7");
        measure_warm(2'b11, "R7");
        measure_warm(2'b00, "R7");

        // wake pulses inside warm-up
        do_halt(2'b01, 1'b1, "R10");
        do_wake(2'b10, "R7");
        for (int i = 0; i < 40; i++) begin
            wake = (i % 3 == 0); wup_code = 2'(i);
            halt_req = (i % 5 == 0); halt_depth = 2'b11;
            step("R8");
        end

        // random phase
        for (int i = 0; i < 6000; i++) begin
            halt_req   = ($urandom % 6) == 0;
            halt_depth = 2'($urandom);
            hold_sel   = 1'($urandom);
            wup_code   = 2'($urandom);
            wake       = ($urandom % 8) == 0;
            step("R9");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule